// File: doc/BRIEF.md
# Fetch-to-Decode Stage Register

This block sits on the boundary between instruction fetch and instruction decode in a five-stage 32-bit RISC-V pipeline. Each rising clock edge can capture the fetch address and the instruction word that goes with it. Decode then sees both values unchanged for the whole of the following cycle.

The hazard unit drives two controls. An active-high write enable freezes the stage when it is low, which holds the current instruction in decode during a load-use stall. An active-high flush replaces the fetched pair with a zero address and the canonical no-op `addi x0,x0,0` (0x00000013), which squashes the slot behind a taken branch. The flush is a 2-to-1 select placed in front of the enable-gated registers, so it only commits when the write enable is also high. Software and the hazard unit must never raise flush while the enable is low. If that happens anyway, the stage keeps its old contents. A synchronous active-high reset loads the same no-op pair, so decode starts from a harmless instruction.

Top module: `fd_stage_reg`

## Requirements
- R1: While `rst` is 1 at a rising edge, that edge loads `pc_out` = 0x00000000 and `instr_out` = 0x00000013.
- R2: With `rst`=0, `wr_en`=1 and `flush`=0, a rising edge copies `pc_in` to `pc_out` and `instr_in` to `instr_out`, all 32 bits of each.
- R3: With `rst`=0, `wr_en`=1 and `flush`=1, a rising edge loads `pc_out` = 0x00000000 and `instr_out` = 0x00000013, and the live inputs have no effect.
- R4: With `rst`=0, `wr_en`=0 and `flush`=0, a rising edge leaves both outputs unchanged, whatever values `pc_in` and `instr_in` carry.
- R5: With `rst`=0, `wr_en`=0 and `flush`=1 (the combination the hazard unit must not produce), a rising edge leaves both outputs unchanged. The flush has no effect without a write.
- R6: Load-use stall case: the stage holds PC 0x00000018 with instruction 0x00520233. While 0x0000001C / 0x00A502B3 is presented with `wr_en`=0, the edge leaves the outputs at 0x00000018 / 0x00520233.
- R7: The outputs come straight from flops. A change on `pc_in`, `instr_in`, `wr_en` or `flush` between edges does not change `pc_out` or `instr_out` before the next rising edge.
- R8: Reset takes priority. `rst`=1 gives the R1 values regardless of `wr_en` and `flush`, including `wr_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Stage write enable; 0 freezes both registers |
| flush | input | 1 | Replace the fetched pair with zero PC and no-op; effective only with `wr_en`=1 |
| pc_in | input | 32 | Fetch address of the incoming instruction |
| instr_in | input | 32 | Incoming instruction word |
| pc_out | output | 32 | Registered address presented to decode |
| instr_out | output | 32 | Registered instruction presented to decode |

## Verification
The hardest situation to reach is the forbidden flush-while-frozen combination: a correct hazard unit never produces it, yet the design must visibly ignore it. The stimulus drives it on purpose, both in a directed step and inside random sequences. Those sequences include runs of back-to-back stalls that end in a flush. The bench also loads a known pair and then stalls on different data to replay the load-use case. Between edges it moves every input to show that the outputs do not follow.

// File: rtl/fd_stage_pkg.sv
package fd_stage_pkg;

    localparam int XLEN = 32;

    localparam logic [XLEN-1:0] NOP_WORD = 32'h0000_0013;
    localparam logic [XLEN-1:0] ZERO_PC  = '0;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] instr;
    } fd_slot_t;

    function automatic fd_slot_t bubble_slot();
        fd_slot_t s;
        s.pc    = ZERO_PC;
        s.instr = NOP_WORD;
        return s;
    endfunction

endpackage

// File: rtl/fd_inject_mux.sv
module fd_inject_mux
    import fd_stage_pkg::*;
(
    input  logic     flush,
    input  fd_slot_t live,
    output fd_slot_t next_slot
);

    always_comb begin
        if (flush) begin
            next_slot = bubble_slot();
        end else begin
            next_slot = live;
        end
    end

endmodule

// File: rtl/fd_hold_reg.sv
module fd_hold_reg #(
    parameter int              W       = 32,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RST_VAL;
        end else if (en) begin
            q <= d;
        end
    end

endmodule

// File: rtl/fd_stage_reg.sv
module fd_stage_reg
    import fd_stage_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic            flush,
    input  logic [XLEN-1:0] pc_in,
    input  logic [XLEN-1:0] instr_in,
    output logic [XLEN-1:0] pc_out,
    output logic [XLEN-1:0] instr_out
);

    fd_slot_t live_slot;
    fd_slot_t mux_slot;

    assign live_slot.pc    = pc_in;
    assign live_slot.instr = instr_in;

    fd_inject_mux u_mux (
        .flush     (flush),
        .live      (live_slot),
        .next_slot (mux_slot)
    );

    fd_hold_reg #(
        .W       (XLEN),
        .RST_VAL (ZERO_PC)
    ) u_pc_reg (
        .clk (clk),
        .rst (rst),
        .en  (wr_en),
        .d   (mux_slot.pc),
        .q   (pc_out)
    );

    fd_hold_reg #(
        .W       (XLEN),
        .RST_VAL (NOP_WORD)
    ) u_instr_reg (
        .clk (clk),
        .rst (rst),
        .en  (wr_en),
        .d   (mux_slot.instr),
        .q   (instr_out)
    );

endmodule

// File: rtl/fd_stage_chk.sv
module fd_stage_chk
    import fd_stage_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            wr_en,
    input logic            flush,
    input logic [XLEN-1:0] pc_in,
    input logic [XLEN-1:0] instr_in,
    input logic [XLEN-1:0] pc_out,
    input logic [XLEN-1:0] instr_out
);

    // R1 / R8: leaving reset, the stage holds the no-op pair
    p_reset_nop_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pc_out == ZERO_PC && instr_out == NOP_WORD));

    // R2: plain capture
    p_capture_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !flush) |=> (pc_out == $past(pc_in) && instr_out == $past(instr_in)));

    // R3: flush injects the bubble
    p_bubble_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && flush) |=> (pc_out == ZERO_PC && instr_out == NOP_WORD));

    // R4 / R5: frozen stage keeps its contents, flush or not
    p_freeze_r4: assert property (@(posedge clk) disable iff (rst)
        (!wr_en) |=> ($stable(pc_out) && $stable(instr_out)));

endmodule

bind fd_stage_reg fd_stage_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .flush     (flush),
    .pc_in     (pc_in),
    .instr_in  (instr_in),
    .pc_out    (pc_out),
    .instr_out (instr_out)
);

// File: tb/sim_fd_stage_reg.sv
`timescale 1ns/1ps
module sim_fd_stage_reg;

    localparam logic [31:0] NOP = 32'h0000_0013;

    typedef struct {
        logic [31:0] pc;
        logic [31:0] ins;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        flush = 1'b0;
    logic [31:0] pc_in = '0;
    logic [31:0] instr_in = '0;
    logic [31:0] pc_out;
    logic [31:0] instr_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    exp_t        sb[$];
    logic [31:0] cur_pc = '0;
    logic [31:0] cur_ins = NOP;

    always #4 clk = ~clk;

    fd_stage_reg u0 (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .flush     (flush),
        .pc_in     (pc_in),
        .instr_in  (instr_in),
        .pc_out    (pc_out),
        .instr_out (instr_out)
    );

    task automatic step(input logic r, input logic w, input logic f,
                        input logic [31:0] p, input logic [31:0] i, input string force_tag);
        exp_t e;
        @(negedge clk);
        rst = r; wr_en = w; flush = f; pc_in = p; instr_in = i;
        #1;
        total++;
        if (pc_out !== cur_pc || instr_out !== cur_ins) begin
            bad++;
            $display("FAIL R7 between edges: actual %h/%h expected %h/%h",
                     pc_out, instr_out, cur_pc, cur_ins);
        end
        if (r) begin
            cur_pc = '0; cur_ins = NOP; e.tag = "R1";
        end else if (w && f) begin
            cur_pc = '0; cur_ins = NOP; e.tag = "R3";
        end else if (w) begin
            cur_pc = p; cur_ins = i; e.tag = "R2";
        end else if (f) begin
            e.tag = "R5";
        end else begin
            e.tag = "R4";
        end
        if (force_tag != "") e.tag = force_tag;
        e.pc = cur_pc;
        e.ins = cur_ins;
        sb.push_back(e);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                total++;
                if (pc_out !== e.pc || instr_out !== e.ins) begin
                    bad++;
                    $display("FAIL %s: actual %h/%h expected %h/%h",
                             e.tag, pc_out, instr_out, e.pc, e.ins);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired: actual hung expected finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : driver
        void'($urandom(32'h5eed_1234));
        // R1 reset state
        step(1'b1, 1'b0, 1'b0, 32'hDEAD_BEEF, 32'hCAFE_F00D, "R1");
        step(1'b1, 1'b1, 1'b0, 32'h1111_1111, 32'h2222_2222, "R1");
        // R8 reset wins over flush and over a frozen stage
        step(1'b0, 1'b1, 1'b0, 32'h0000_0040, 32'h0041_0113, "");
        step(1'b1, 1'b0, 1'b1, 32'h3333_3333, 32'h4444_4444, "R8");
        step(1'b0, 1'b1, 1'b0, 32'h0000_0044, 32'hFFFF_FFFF, "");
        step(1'b1, 1'b0, 1'b0, 32'h5555_5555, 32'h6666_6666, "R8");
        // R2 capture with full-width patterns
        step(1'b0, 1'b1, 1'b0, 32'hFFFF_FFFC, 32'hFFFF_FFFF, "R2");
        step(1'b0, 1'b1, 1'b0, 32'hAAAA_AAA8, 32'h5555_5555, "R2");
        // R3 flush
        step(1'b0, 1'b1, 1'b1, 32'h0000_0100, 32'h00C5_8633, "R3");
        // R6 load-use stall
        step(1'b0, 1'b1, 1'b0, 32'h0000_0018, 32'h0052_0233, "R2");
        step(1'b0, 1'b0, 1'b0, 32'h0000_001C, 32'h00A5_02B3, "R6");
        step(1'b0, 1'b0, 1'b0, 32'h0000_001C, 32'h00A5_02B3, "R6");
        // R5 flush while frozen is ignored
        step(1'b0, 1'b0, 1'b1, 32'h0000_0020, 32'h0000_0000, "R5");
        // R4 back-to-back stalls then a flush
        step(1'b0, 1'b1, 1'b0, 32'h0000_0200, 32'h1234_5678, "R2");
        step(1'b0, 1'b0, 1'b0, 32'h0000_0204, 32'h8765_4321, "R4");
        step(1'b0, 1'b0, 1'b0, 32'h0000_0208, 32'h0BAD_0BAD, "R4");
        step(1'b0, 1'b1, 1'b1, 32'h0000_020C, 32'h0F0F_0F0F, "R3");
        // random mixes of stall, flush and data
        for (int n = 0; n < 400; n++) begin
            logic w, f;
            w = ($urandom_range(0, 3) != 0);
            f = ($urandom_range(0, 3) == 0);
            step(1'b0, w, f, $urandom, $urandom, "");
        end
        step(1'b0, 1'b0, 1'b0, 32'h0, 32'h0, "R4");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule